// File: doc/BRIEF.md
# Write-Once Wiper Slot Store Controller

This controller keeps a bank of twenty write-once slots, each holding a saved 10-bit wiper position. It sits between a command decoder and the wiper register. Store requests append the current wiper value to the next unused slot. The bank is append-only, so it also serves as a history of every saved position. A program-and-verify sequence runs on each store. Once that sequence has finished, a success flag reports whether the value read back from the slot matches the value that was written.

Refresh requests reload the wiper from the newest slot. So do rising edges on a hardware reset input and the power-on restore that follows the synchronous reset. When no slot has been written, the reload value is midscale.

Read requests return one of three things: a slot's contents, one of two thermometer-coded usage words, or zero for an address that is not mapped. The write-once array is modelled as a register array. Its program and restore durations are parameters counted in system clock cycles. While either sequence runs, a busy flag is high and every new request is ignored.

Top module: `slot_store_ctrl`

## Requirements
- R1: There are 20 slots at read addresses 0x00 to 0x13. Each accepted store writes `wiper_in` into the lowest unused slot. A read of a slot that has not been written returns 0.
- R2: Address 0x14 returns a status word whose bit i is 1 when more than i slots are used. Address 0x15 returns a status word whose bit i is 1 when more than 10+i slots are used.
- R3: The index of the newest used slot equals the number of ones in word 0x14, plus the number of ones in word 0x15, minus 1. For example, with 18 slots used the words are 0x3FF and 0x0FF, giving 17.
- R4: `success` is cleared when a store is accepted. It is set at the end of that store only if the slot, read back, matches the stored value.
- R5: After the clock edge that accepts a store, `busy` is high for exactly PROG_CYCLES cycles. Store, refresh, read and hardware-reset requests that arrive while `busy` is high are ignored, and `read_data` keeps its value.
- R6: A refresh request, or a rising edge on `hw_reset_in`, holds `busy` high for exactly RESTORE_CYCLES cycles. In the first cycle after that, `busy` is low, `wiper_load` pulses high for one cycle and `wiper_value` holds the newest slot's value.
- R7: When no slot has been written, every restore loads midscale, 0x200.
- R8: After `rst` is released, a restore runs automatically: `busy` is high, and then `wiper_load` pulses with the restore value.
- R9: A store while all 20 slots are used is rejected. `busy` stays low, `success` is 0 in the next cycle, and no slot or status word changes.
- R10: `read_data` updates in the cycle after an accepted read. A read of an address above 0x15 returns 0.
- R11: When several requests are present in the same idle cycle, a rising edge on `hw_reset_in` wins over a store, a store wins over a refresh, and a refresh wins over a read. Every request that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| hw_reset_in | input | 1 | Hardware reset; a rising edge requests a restore |
| store_req | input | 1 | Append `wiper_in` to the next free slot |
| wiper_in | input | 10 | Current wiper value to store |
| refresh_req | input | 1 | Reload the wiper from the newest slot |
| read_req | input | 1 | Read the location at `read_addr` |
| read_addr | input | 5 | Slot (0x00-0x13), status word (0x14, 0x15), anything else reads 0 |
| read_data | output | 10 | Registered read result |
| busy | output | 1 | Program or restore sequence in progress |
| success | output | 1 | Last store verified correctly |
| wiper_load | output | 1 | One-cycle strobe: load `wiper_value` into the wiper |
| wiper_value | output | 10 | Restore value for the wiper register |

## Verification
Two functions can collide in one idle cycle. The first collision is a store and a hardware-reset rising edge. The bench raises `store_req` and `hw_reset_in` together, then judges the result by three observations: `wiper_load` delivers the previous newest value after exactly RESTORE_CYCLES busy cycles, the usage status word shows no new slot, and `success` is unchanged. The second collision is a store that arrives together with a read while a program sequence is already running. The bench checks that the store was dropped through the status count and the untouched next slot, and that the read was dropped through the unchanged `read_data`.

// File: rtl/slot_store_pkg.sv
package slot_store_pkg;

    localparam int unsigned DEF_SLOTS          = 20;
    localparam int unsigned DEF_DATA_W         = 10;
    localparam int unsigned DEF_PROG_CYCLES    = 12;
    localparam int unsigned DEF_RESTORE_CYCLES = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROG,
        ST_VERIFY,
        ST_RESTORE
    } ctl_state_e;

    typedef struct packed {
        logic store;
        logic refresh;
        logic read;
    } req_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/slot_bank.sv
module slot_bank #(
    parameter int unsigned SLOTS  = 20,
    parameter int unsigned DATA_W = 10,
    localparam int unsigned IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  nw_idx,
    output logic [DATA_W-1:0] nw_data
);
    logic [DATA_W-1:0] cells [SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(SLOTS); i++) cells[i] <= '0;
        end else if (we && (32'(wr_idx) < SLOTS)) begin
            cells[wr_idx] <= wr_data;
        end
    end

    assign rd_data = (32'(rd_idx) < SLOTS) ? cells[rd_idx] : '0;
    assign nw_data = (32'(nw_idx) < SLOTS) ? cells[nw_idx] : '0;
endmodule

// File: rtl/usage_status.sv
module usage_status #(
    parameter int unsigned SLOTS  = 20,
    parameter int unsigned DATA_W = 10,
    localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
    input  logic [CNT_W-1:0]  used_cnt,
    output logic [DATA_W-1:0] lo_word,
    output logic [DATA_W-1:0] hi_word
);
    for (genvar i = 0; i < int'(DATA_W); i++) begin : g_therm
        assign lo_word[i] = (32'(used_cnt) > i);
        assign hi_word[i] = (32'(used_cnt) > (DATA_W + i));
    end
endmodule

// File: rtl/slot_store_ctrl.sv
module slot_store_ctrl
    import slot_store_pkg::*;
#(
    parameter int unsigned SLOTS          = DEF_SLOTS,
    parameter int unsigned DATA_W         = DEF_DATA_W,
    parameter int unsigned PROG_CYCLES    = DEF_PROG_CYCLES,
    parameter int unsigned RESTORE_CYCLES = DEF_RESTORE_CYCLES,
    localparam int unsigned ADDR_W = $clog2(SLOTS + 2),
    localparam int unsigned CNT_W  = $clog2(SLOTS + 1),
    localparam int unsigned IDX_W  = $clog2(SLOTS),
    localparam int unsigned TMR_W  = $clog2(max2(PROG_CYCLES, RESTORE_CYCLES) + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_reset_in,
    input  logic              store_req,
    input  logic [DATA_W-1:0] wiper_in,
    input  logic              refresh_req,
    input  logic              read_req,
    input  logic [ADDR_W-1:0] read_addr,
    output logic [DATA_W-1:0] read_data,
    output logic              busy,
    output logic              success,
    output logic              wiper_load,
    output logic [DATA_W-1:0] wiper_value
);
    localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);

    ctl_state_e        state;
    logic [TMR_W-1:0]  tmr;
    logic [CNT_W-1:0]  used_cnt;
    logic [CNT_W-1:0]  newest_cnt;
    logic [DATA_W-1:0] pend_val;
    logic              hw_q;
    logic              hw_rise;
    logic              full;
    req_t              req;

    logic              bank_we;
    logic [IDX_W-1:0]  bank_rd_idx;
    logic [DATA_W-1:0] bank_rd_data;
    logic [DATA_W-1:0] bank_nw_data;
    logic [DATA_W-1:0] stat_lo;
    logic [DATA_W-1:0] stat_hi;
    logic [DATA_W-1:0] rd_mux;

    assign hw_rise    = hw_reset_in & ~hw_q;
    assign full       = (used_cnt == CNT_W'(SLOTS));
    assign newest_cnt = used_cnt - CNT_W'(1);
    assign busy       = (state != ST_IDLE);

    // Arbitration in an idle cycle: hardware edge, store, refresh, read.
    always_comb begin
        req = '0;
        if (state == ST_IDLE) begin
            if (hw_rise)          req.refresh = 1'b1;
            else if (store_req)   req.store   = 1'b1;
            else if (refresh_req) req.refresh = 1'b1;
            else if (read_req)    req.read    = 1'b1;
        end
    end

    assign bank_we     = (state == ST_PROG) && (tmr == TMR_W'(1));
    assign bank_rd_idx = (state == ST_VERIFY) ? used_cnt[IDX_W-1:0] : read_addr[IDX_W-1:0];

    slot_bank #(.SLOTS(SLOTS), .DATA_W(DATA_W)) i_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (bank_we),
        .wr_idx  (used_cnt[IDX_W-1:0]),
        .wr_data (pend_val),
        .rd_idx  (bank_rd_idx),
        .rd_data (bank_rd_data),
        .nw_idx  (newest_cnt[IDX_W-1:0]),
        .nw_data (bank_nw_data)
    );

    usage_status #(.SLOTS(SLOTS), .DATA_W(DATA_W)) i_status (
        .used_cnt (used_cnt),
        .lo_word  (stat_lo),
        .hi_word  (stat_hi)
    );

    always_comb begin
        if (read_addr < ADDR_W'(SLOTS))           rd_mux = bank_rd_data;
        else if (read_addr == ADDR_W'(SLOTS))     rd_mux = stat_lo;
        else if (read_addr == ADDR_W'(SLOTS + 1)) rd_mux = stat_hi;
        else                                      rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_RESTORE;
            tmr         <= TMR_W'(RESTORE_CYCLES - 1);
            used_cnt    <= '0;
            pend_val    <= '0;
            success     <= 1'b0;
            wiper_load  <= 1'b0;
            wiper_value <= '0;
            read_data   <= '0;
            hw_q        <= 1'b0;
        end else begin
            hw_q       <= hw_reset_in;
            wiper_load <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req.refresh) begin
                        state <= ST_RESTORE;
                        tmr   <= TMR_W'(RESTORE_CYCLES - 1);
                    end else if (req.store) begin
                        success <= 1'b0;
                        if (!full) begin
                            state    <= ST_PROG;
                            tmr      <= TMR_W'(PROG_CYCLES - 1);
                            pend_val <= wiper_in;
                        end
                    end else if (req.read) begin
                        read_data <= rd_mux;
                    end
                end
                ST_PROG: begin
                    if (tmr == TMR_W'(1)) state <= ST_VERIFY;
                    else                  tmr   <= tmr - TMR_W'(1);
                end
                ST_VERIFY: begin
                    success  <= (bank_rd_data == pend_val);
                    used_cnt <= used_cnt + CNT_W'(1);
                    state    <= ST_IDLE;
                end
                ST_RESTORE: begin
                    if (tmr == '0) begin
                        wiper_load  <= 1'b1;
                        wiper_value <= (used_cnt == '0) ? MIDSCALE : bank_nw_data;
                        state       <= ST_IDLE;
                    end else begin
                        tmr <= tmr - TMR_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/slot_store_chk.sv
module slot_store_chk #(
    parameter int unsigned SLOTS          = 20,
    parameter int unsigned DATA_W         = 10,
    parameter int unsigned PROG_CYCLES    = 12,
    parameter int unsigned RESTORE_CYCLES = 5,
    localparam int unsigned ADDR_W = $clog2(SLOTS + 2),
    localparam int unsigned CNT_W  = $clog2(SLOTS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              hw_reset_in,
    input logic              store_req,
    input logic              refresh_req,
    input logic              read_req,
    input logic [ADDR_W-1:0] read_addr,
    input logic [DATA_W-1:0] read_data,
    input logic              busy,
    input logic              success,
    input logic              wiper_load,
    input logic [CNT_W-1:0]  used_cnt
);
    logic [15:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= '0;
        else if (busy) busy_run <= busy_run + 16'd1;
        else           busy_run <= '0;
    end

    // R5 R6
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == 16'(PROG_CYCLES) || busy_run == 16'(RESTORE_CYCLES)));

    // R6
    load_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        wiper_load |-> (!busy && $past(busy)));

    // R4
    success_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(success) |-> $fell(busy));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (read_req && !busy && !store_req && !refresh_req && !$rose(hw_reset_in)
         && read_addr > ADDR_W'(SLOTS + 1)) |=> (read_data == '0));

    // R1 R9
    append_only_chk: assert property (@(posedge clk) disable iff (rst)
        (used_cnt != $past(used_cnt)) |-> (used_cnt == $past(used_cnt) + CNT_W'(1)
                                           && used_cnt <= CNT_W'(SLOTS)));
endmodule

bind slot_store_ctrl slot_store_chk #(
    .SLOTS(SLOTS), .DATA_W(DATA_W),
    .PROG_CYCLES(PROG_CYCLES), .RESTORE_CYCLES(RESTORE_CYCLES)
) i_chk (
    .clk(clk), .rst(rst), .hw_reset_in(hw_reset_in), .store_req(store_req),
    .refresh_req(refresh_req), .read_req(read_req), .read_addr(read_addr),
    .read_data(read_data), .busy(busy), .success(success),
    .wiper_load(wiper_load), .used_cnt(used_cnt)
);

// File: tb/test_slot_store_ctrl.sv
module test_slot_store_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PROG_N     = 12;
    localparam int REST_N     = 5;

    localparam logic [1:0] OP_STORE = 2'd0;
    localparam logic [1:0] OP_READ  = 2'd1;
    localparam logic [1:0] OP_REFR  = 2'd2;
    localparam logic [1:0] OP_HW    = 2'd3;

    typedef struct packed {
        logic [1:0] op;
        logic [9:0] arg;
        logic [9:0] exp;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        '{OP_READ,  10'h014, 10'h000},
        '{OP_READ,  10'h015, 10'h000},
        '{OP_REFR,  10'h000, 10'h200},
        '{OP_STORE, 10'h100, 10'h001},
        '{OP_READ,  10'h000, 10'h100},
        '{OP_REFR,  10'h000, 10'h100},
        '{OP_STORE, 10'h2AB, 10'h001},
        '{OP_HW,    10'h000, 10'h2AB},
        '{OP_READ,  10'h014, 10'h003},
        '{OP_READ,  10'h001, 10'h2AB},
        '{OP_READ,  10'h01F, 10'h000},
        '{OP_READ,  10'h016, 10'h000},
        '{OP_READ,  10'h005, 10'h000}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hw_reset_in = 1'b0;
    logic       store_req = 1'b0;
    logic [9:0] wiper_in = '0;
    logic       refresh_req = 1'b0;
    logic       read_req = 1'b0;
    logic [4:0] read_addr = '0;
    logic [9:0] read_data;
    logic       busy, success, wiper_load;
    logic [9:0] wiper_value;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_store_ctrl #(.PROG_CYCLES(PROG_N), .RESTORE_CYCLES(REST_N)) i_slot_store_ctrl (
        .clk(clk), .rst(rst), .hw_reset_in(hw_reset_in), .store_req(store_req),
        .wiper_in(wiper_in), .refresh_req(refresh_req), .read_req(read_req),
        .read_addr(read_addr), .read_data(read_data), .busy(busy),
        .success(success), .wiper_load(wiper_load), .wiper_value(wiper_value)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input bit st, input bit rf, input bit rd, input bit hw,
                         input logic [4:0] a, input logic [9:0] d);
        @(negedge clk);
        store_req = st; refresh_req = rf; read_req = rd; hw_reset_in = hw;
        read_addr = a; wiper_in = d;
        @(negedge clk);
        store_req = 0; refresh_req = 0; read_req = 0; hw_reset_in = 0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_store(input logic [9:0] v, output bit ok, output int n);
        pulse(1, 0, 0, 0, 5'd0, v);
        wait_idle(n);
        ok = success;
    endtask

    task automatic do_read(input logic [4:0] a, output logic [9:0] d);
        pulse(0, 0, 1, 0, a, 10'd0);
        d = read_data;
    endtask

    task automatic do_restore(input bit hw, output logic [9:0] v, output int n, output bit ld);
        pulse(0, !hw, 0, hw, 5'd0, 10'd0);
        wait_idle(n);
        ld = wiper_load;
        v  = wiper_value;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [9:0] d, v;
        int n;
        bit ok, ld;
        logic [9:0] fill [20];

        // Reset state and R8 power-on restore of an empty bank (R7)
        repeat (3) @(negedge clk);
        check(busy == 1'b1 && wiper_load == 1'b0 && success == 1'b0, "R8 reset state", {busy, wiper_load, success}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        wait_idle(n);
        check(wiper_load == 1'b1, "R8 power-on load strobe", wiper_load, 1);
        check(wiper_value == 10'h200, "R7 power-on midscale", wiper_value, 10'h200);
        @(negedge clk);
        check(wiper_load == 1'b0, "R6 load strobe one cycle", wiper_load, 0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i].op)
                OP_STORE: begin
                    do_store(VEC[i].arg, ok, n);
                    check(ok == VEC[i].exp[0], "R4 store success", ok, VEC[i].exp[0]);
                    check(n == PROG_N, "R5 program busy length", n, PROG_N);
                end
                OP_READ: begin
                    do_read(VEC[i].arg[4:0], d);
                    check(d == VEC[i].exp, "R1 R2 R10 read data", d, VEC[i].exp);
                end
                default: begin
                    do_restore(VEC[i].op == OP_HW, v, n, ld);
                    check(ld && v == VEC[i].exp, "R6 R7 restore value", v, VEC[i].exp);
                    check(n == REST_N, "R6 restore busy length", n, REST_N);
                end
            endcase
        end

        // R11: hardware edge and store in the same cycle; the edge wins
        pulse(1, 0, 0, 1, 5'd0, 10'h0AA);
        wait_idle(n);
        check(wiper_load && wiper_value == 10'h2AB, "R11 hw edge beats store", wiper_value, 10'h2AB);
        check(n == REST_N, "R11 restore length on collision", n, REST_N);
        do_read(5'h14, d);
        check(d == 10'h003, "R11 store dropped", d, 10'h003);
        check(success == 1'b1, "R11 success untouched", success, 1);

        // R5: requests while busy are ignored
        pulse(1, 0, 0, 0, 5'd0, 10'h155);
        repeat (3) @(negedge clk);
        pulse(1, 0, 1, 0, 5'h02, 10'h0F0);
        check(read_data == 10'h003, "R5 read ignored while busy", read_data, 10'h003);
        wait_idle(n);
        check(n == PROG_N - 5, "R5 busy not extended", n, PROG_N - 5);
        do_read(5'h14, d);
        check(d == 10'h007, "R5 R2 one slot added", d, 10'h007);
        do_read(5'h03, d);
        check(d == 10'h000, "R5 locked store not written", d, 10'h000);
        do_read(5'h02, d);
        check(d == 10'h155, "R1 slot 2 value", d, 10'h155);

        // Fill up to 18 used slots
        for (int i = 3; i < 20; i++) fill[i] = 10'((i * 37) + 5);
        for (int i = 3; i < 18; i++) begin
            do_store(fill[i], ok, n);
            check(ok, "R4 fill store success", ok, 1);
        end
        do_read(5'h14, d);
        check(d == 10'h3FF, "R2 low word at 18", d, 10'h3FF);
        do_read(5'h15, v);
        check(v == 10'h0FF, "R2 high word at 18", v, 10'h0FF);
        check(($countones(d) + $countones(v) - 1) == 17, "R3 newest address", $countones(d) + $countones(v) - 1, 17);
        do_read(5'h11, d);
        check(d == fill[17], "R1 slot 17", d, fill[17]);

        for (int i = 18; i < 20; i++) begin
            do_store(fill[i], ok, n);
            check(ok && n == PROG_N, "R4 R5 last stores", n, PROG_N);
        end
        do_read(5'h15, d);
        check(d == 10'h3FF, "R2 high word full", d, 10'h3FF);

        // R9: store when full is rejected
        pulse(1, 0, 0, 0, 5'd0, 10'h3C3);
        check(busy == 1'b0, "R9 no busy on full", busy, 0);
        check(success == 1'b0, "R9 success cleared", success, 0);
        do_read(5'h13, d);
        check(d == fill[19], "R9 last slot unchanged", d, fill[19]);
        do_read(5'h15, d);
        check(d == 10'h3FF, "R9 status unchanged", d, 10'h3FF);
        do_restore(0, v, n, ld);
        check(ld && v == fill[19], "R6 restore newest of full bank", v, fill[19]);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule